// File: doc/BRIEF.md
# Streaming Sobel Gradient Magnitude Unit

This block takes a raster-ordered greyscale pixel stream, one pixel per clock at most, and produces an edge strength value for every interior window position. Two line memories hold the two earlier rows and three column registers hold the last three columns of the window, so each pixel enters the block only once. The horizontal and vertical Sobel responses are formed from the nine window pixels. They are then combined through a cheap norm in place of a square root: either the sum of the absolute values or the larger of the two. The result is clipped to the output width.

The source marks the last pixel of each line with an end-of-line flag, and the line length may be anything from 2 up to the configured maximum. Window columns that fall outside the line take copies of the edge pixel. One result comes out for every accepted pixel once two complete rows and two further pixels have entered. The result for the last column of a line leaves with the first pixel of the following line, so the output keeps up with the input and needs no flush cycle. Idle cycles may be inserted anywhere in the stream.

Top module: `edge_mag_stream`

## Requirements
- R1: While reset is asserted, and afterwards until a result is due, `out_valid` is 0 and `out_mag` is 0.
- R2: No result is produced until two complete lines plus two pixels have been accepted. From then on, each accepted pixel yields exactly one result, in order. A pixel at column c ≥ 1 of line r ≥ 2 yields the window centred at line r-1, column c-1. A pixel at column 0 of line r ≥ 3 yields the window centred at line r-2 on the last column of that line.
- R3: With P(dy,dx) the pixel at that offset from the centre, the horizontal response is P(-1,1)+2P(0,1)+P(1,1)-P(-1,-1)-2P(0,-1)-P(1,-1). The vertical response is P(1,-1)+2P(1,0)+P(1,1)-P(-1,-1)-2P(-1,0)-P(-1,1). Each absolute value is at most 4·(2^PIX_W-1).
- R4: A window column left of column 0 or right of the last column repeats the pixels of the edge column.
- R5: With `norm_sel` = 0 the magnitude is |Gx|+|Gy|.
- R6: With `norm_sel` = 1 the magnitude is max(|Gx|,|Gy|).
- R7: A magnitude above 2^OUT_W-1 is output as 2^OUT_W-1.
- R8: A result shows on `out_valid`/`out_mag` after the second rising edge following the edge that accepted its producing pixel. It holds for one cycle unless the next pixel also produces a result.
- R9: `norm_sel` is sampled together with each pixel and governs the result that pixel produces, so the norm can change from pixel to pixel.
- R10: Cycles with `in_valid` = 0 change no result, whatever `in_pix`, `in_eol` and `norm_sel` carry.
- R11: `in_eol` on the pixel at column w-1 ends a line of length w, for any w from 2 to LINE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Pixel accepted this cycle |
| in_pix | input | PIX_W | Greyscale pixel |
| in_eol | input | 1 | Accepted pixel is the last of its line |
| norm_sel | input | 1 | 0: L1 norm, 1: L-infinity norm, taken with the pixel |
| out_valid | output | 1 | Magnitude valid |
| out_mag | output | OUT_W | Clipped gradient magnitude |

## Verification
The hardest case to reach is the result that leaves at the first pixel of a new line. That result belongs to the previous line's last column and uses a replicated right column. It only appears once at least three lines have entered, and it sits next to the left-edge replication case. The stimulus therefore streams whole frames of several shapes, including a short line and a full-width line, and adds one extra pixel at the start of the next line to release the final result. It also interleaves idle cycles carrying junk data with per-pixel norm changes, to show that the ordering and mode tagging survive gaps.

// File: rtl/edge_mag_pkg.sv
package edge_mag_pkg;
  typedef enum logic {
    NORM_L1   = 1'b0,
    NORM_LINF = 1'b1
  } norm_e;
endpackage

// File: rtl/edge_line_cache.sv
module edge_line_cache
  import edge_mag_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld_i,
  input  logic [PIX_W-1:0]      pix_i,
  input  logic                  eol_i,
  input  norm_e                 sel_i,
  output logic                  win_vld_o,
  output norm_e                 win_sel_o,
  output logic [8:0][PIX_W-1:0] win_o
);
  localparam int COL_W = (LINE_W > 2) ? $clog2(LINE_W) : 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_W - 1);

  logic [PIX_W-1:0] lb_near [LINE_W];
  logic [PIX_W-1:0] lb_far  [LINE_W];

  logic [COL_W-1:0]        col_q, col_d;
  logic [1:0]              rows_q, rows_d;
  logic [2:0][PIX_W-1:0]   colb_q, colc_q, col_vec;
  logic [2:0][PIX_W-1:0]   lft, ctr, rgt;
  logic [8:0][PIX_W-1:0]   win_d, win_q;
  logic                    emit, line_end, vld_q;
  norm_e                   sel_q;

  always_comb begin
    col_vec[0] = lb_far[col_q];
    col_vec[1] = lb_near[col_q];
    col_vec[2] = pix_i;
    if (col_q == '0) begin
      lft = colb_q; ctr = colc_q; rgt = colc_q;
    end else if (col_q == COL_W'(1)) begin
      lft = colc_q; ctr = colc_q; rgt = col_vec;
    end else begin
      lft = colb_q; ctr = colc_q; rgt = col_vec;
    end
    for (int k = 0; k < 3; k++) begin
      win_d[3*k]   = lft[k];
      win_d[3*k+1] = ctr[k];
      win_d[3*k+2] = rgt[k];
    end
    line_end = eol_i || (col_q == COL_LAST);
    col_d    = col_q;
    rows_d   = rows_q;
    if (vld_i) begin
      col_d = line_end ? '0 : col_q + COL_W'(1);
      if (line_end && rows_q != 2'd3) rows_d = rows_q + 2'd1;
    end
    emit = vld_i && (((col_q != '0) && (rows_q >= 2'd2)) ||
                     ((col_q == '0) && (rows_q == 2'd3)));
  end

  always_ff @(posedge clk) begin
    if (vld_i) begin
      lb_near[col_q] <= pix_i;
      lb_far[col_q]  <= lb_near[col_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      rows_q <= '0;
      colb_q <= '0;
      colc_q <= '0;
      win_q  <= '0;
      vld_q  <= 1'b0;
      sel_q  <= NORM_L1;
    end else begin
      col_q  <= col_d;
      rows_q <= rows_d;
      vld_q  <= emit;
      if (vld_i) begin
        colb_q <= colc_q;
        colc_q <= col_vec;
        win_q  <= win_d;
        sel_q  <= sel_i;
      end
    end
  end

  assign win_vld_o = vld_q;
  assign win_sel_o = sel_q;
  assign win_o     = win_q;

  AST_WIN_FROM_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> $past(vld_i)); // R2
endmodule

// File: rtl/edge_grad.sv
module edge_grad
  import edge_mag_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int ABS_W = PIX_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld_i,
  input  norm_e                 sel_i,
  input  logic [8:0][PIX_W-1:0] win_i,
  output logic                  vld_o,
  output norm_e                 sel_o,
  output logic [ABS_W-1:0]      ax_o,
  output logic [ABS_W-1:0]      ay_o
);
  localparam int SUM_W = PIX_W + 3;
  localparam logic [ABS_W-1:0] ABS_MAX = ABS_W'(4 * ((1 << PIX_W) - 1));

  logic signed [SUM_W-1:0] e [9];
  logic signed [SUM_W-1:0] gx, gy;
  logic [SUM_W-1:0]        mx, my;
  logic [ABS_W-1:0]        ax_q, ay_q;
  logic                    vld_q;
  norm_e                   sel_q;

  always_comb begin
    for (int i = 0; i < 9; i++) e[i] = signed'({3'b000, win_i[i]});
    gx = (e[2] + (e[5] <<< 1) + e[8]) - (e[0] + (e[3] <<< 1) + e[6]);
    gy = (e[6] + (e[7] <<< 1) + e[8]) - (e[0] + (e[1] <<< 1) + e[2]);
    mx = gx[SUM_W-1] ? SUM_W'(-gx) : SUM_W'(gx);
    my = gy[SUM_W-1] ? SUM_W'(-gy) : SUM_W'(gy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sel_q <= NORM_L1;
      ax_q  <= '0;
      ay_q  <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        sel_q <= sel_i;
        ax_q  <= mx[ABS_W-1:0];
        ay_q  <= my[ABS_W-1:0];
      end
    end
  end

  assign vld_o = vld_q;
  assign sel_o = sel_q;
  assign ax_o  = ax_q;
  assign ay_o  = ay_q;

  AST_ABS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (ax_o <= ABS_MAX) && (ay_o <= ABS_MAX)); // R3
endmodule

// File: rtl/edge_norm.sv
module edge_norm
  import edge_mag_pkg::*;
#(
  parameter int ABS_W = 10,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  norm_e            sel_i,
  input  logic [ABS_W-1:0] ax_i,
  input  logic [ABS_W-1:0] ay_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] mag_o
);
  localparam int NRM_W = ABS_W + 1;
  localparam int WIDE  = NRM_W + OUT_W;
  localparam logic [WIDE-1:0] CAP = WIDE'((64'd1 << OUT_W) - 64'd1);

  logic [NRM_W-1:0] sum_v, max_v, res_v;
  logic [WIDE-1:0]  res_w;
  logic [OUT_W-1:0] mag_d, mag_q;
  logic             vld_q;

  always_comb begin
    sum_v = {1'b0, ax_i} + {1'b0, ay_i};
    max_v = (ax_i >= ay_i) ? {1'b0, ax_i} : {1'b0, ay_i};
    res_v = (sel_i == NORM_LINF) ? max_v : sum_v;
    res_w = WIDE'(res_v);
    mag_d = (res_w > CAP) ? '1 : res_w[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      mag_q <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) mag_q <= mag_d;
      else       mag_q <= '0;
    end
  end

  assign vld_o = vld_q;
  assign mag_o = mag_q;

  AST_MAG_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (WIDE'(mag_o) == CAP) ||
              ((WIDE'(mag_o) >= WIDE'($past(ax_i))) && (WIDE'(mag_o) >= WIDE'($past(ay_i))))); // R5
  AST_LINF_PICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && sel_i == NORM_LINF) |=> (WIDE'(mag_o) == CAP) ||
              (WIDE'(mag_o) == WIDE'($past(ax_i))) || (WIDE'(mag_o) == WIDE'($past(ay_i)))); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> (mag_o == '0)); // R1
endmodule

// File: rtl/edge_mag_stream.sv
module edge_mag_stream
  import edge_mag_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 64,
  parameter int OUT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_eol,
  input  logic             norm_sel,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_mag
);
  localparam int ABS_W = PIX_W + 2;

  logic                  rst_meta, rst_q;
  logic                  w_vld, g_vld;
  norm_e                 w_sel, g_sel;
  logic [8:0][PIX_W-1:0] w_win;
  logic [ABS_W-1:0]      g_ax, g_ay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  edge_line_cache #(.PIX_W(PIX_W), .LINE_W(LINE_W)) cache_i (
    .clk(clk), .rst_n(rst_q), .vld_i(in_valid), .pix_i(in_pix), .eol_i(in_eol),
    .sel_i(norm_e'(norm_sel)), .win_vld_o(w_vld), .win_sel_o(w_sel), .win_o(w_win)
  );

  edge_grad #(.PIX_W(PIX_W)) grad_i (
    .clk(clk), .rst_n(rst_q), .vld_i(w_vld), .sel_i(w_sel), .win_i(w_win),
    .vld_o(g_vld), .sel_o(g_sel), .ax_o(g_ax), .ay_o(g_ay)
  );

  edge_norm #(.ABS_W(ABS_W), .OUT_W(OUT_W)) norm_i (
    .clk(clk), .rst_n(rst_q), .vld_i(g_vld), .sel_i(g_sel), .ax_i(g_ax), .ay_i(g_ay),
    .vld_o(out_valid), .mag_o(out_mag)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> $past(in_valid, 3)); // R8
endmodule

// File: tb/edge_mag_stream_tb_top.sv
`timescale 1ns/1ps
module edge_mag_stream_tb_top;
  localparam int PW = 8;
  localparam int LW = 16;
  localparam int OW = 10;
  localparam int CAPV = (1 << OW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_eol, norm_sel;
  logic [PW-1:0] in_pix;
  logic          out_valid;
  logic [OW-1:0] out_mag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  int img [0:15][0:15];
  int exp_val [$];
  int in_cyc  [$];
  int out_val [$];
  int out_cyc [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_mag_stream #(.PIX_W(PW), .LINE_W(LW), .OUT_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix), .in_eol(in_eol),
    .norm_sel(norm_sel), .out_valid(out_valid), .out_mag(out_mag)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      out_val.push_back(int'(out_mag));
      out_cyc.push_back(cyc);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF);
  endfunction

  function automatic int px(input int r, input int c, input int w);
    int cc = (c < 0) ? 0 : ((c > w - 1) ? w - 1 : c);
    return img[r][cc];
  endfunction

  function automatic int model(input int r, input int c, input int w, input int mode);
    int gx, gy, ax, ay, m;
    gx = px(r-1,c+1,w) + 2*px(r,c+1,w) + px(r+1,c+1,w)
       - px(r-1,c-1,w) - 2*px(r,c-1,w) - px(r+1,c-1,w);
    gy = px(r+1,c-1,w) + 2*px(r+1,c,w) + px(r+1,c+1,w)
       - px(r-1,c-1,w) - 2*px(r-1,c,w) - px(r-1,c+1,w);
    ax = (gx < 0) ? -gx : gx;
    ay = (gy < 0) ? -gy : gy;
    m = (mode != 0) ? ((ax > ay) ? ax : ay) : ax + ay;
    return (m > CAPV) ? CAPV : m;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_eol = 1'b0; norm_sel = 1'b0; in_pix = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_mag == '0, "R1 during reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && out_mag == '0, "R1 after release", int'(out_mag), 0);
    exp_val.delete(); in_cyc.delete(); out_val.delete(); out_cyc.delete();
  endtask

  // mode_kind: 0 L1, 1 Linf, 2 alternate per pixel; gap: idle cycles between pixels
  task automatic run_frame(input int w, input int h, input int mode_kind, input int gap,
                           input string tag);
    int p = 0;
    int n_ok = 0;
    do_reset();
    for (int r = 0; r <= h; r++) begin
      for (int c = 0; c < w; c++) begin
        int md;
        if (r == h && c > 0) break;
        md = (mode_kind == 2) ? (p % 2) : mode_kind;
        in_valid = 1'b1;
        in_pix   = (r == h) ? '0 : PW'(img[r][c]);
        in_eol   = (c == w - 1);
        norm_sel = md[0];
        if (c >= 1 && r >= 2) begin
          exp_val.push_back(model(r-1, c-1, w, md)); in_cyc.push_back(cyc);
        end else if (c == 0 && r >= 3) begin
          exp_val.push_back(model(r-2, w-1, w, md)); in_cyc.push_back(cyc);
        end
        p++;
        @(negedge clk);
        for (int g = 0; g < gap; g++) begin
          in_valid = 1'b0; in_pix = PW'(rnd()); in_eol = rnd()[0]; norm_sel = ~norm_sel;
          @(negedge clk);
        end
      end
    end
    in_valid = 1'b0; in_eol = 1'b0;
    repeat (6) @(negedge clk);
    check(out_val.size() == exp_val.size(), {tag, " R2 result count"},
          out_val.size(), exp_val.size());
    for (int k = 0; k < exp_val.size() && k < out_val.size(); k++) begin
      if (out_val[k] == exp_val[k] && out_cyc[k] == in_cyc[k] + 3) n_ok++;
      else begin
        check(out_val[k] == exp_val[k], {tag, " value"}, out_val[k], exp_val[k]);
        check(out_cyc[k] == in_cyc[k] + 3, {tag, " R8 latency"}, out_cyc[k] - in_cyc[k], 3);
      end
    end
    check(n_ok == exp_val.size(), {tag, " all results"}, n_ok, exp_val.size());
  endtask

  task automatic t_ramp_l1();
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) img[r][c] = c*13 + r*5;
    run_frame(8, 5, 0, 0, "R3 R4 R5 ramp L1");
  endtask

  task automatic t_random_l1();
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) img[r][c] = rnd();
    run_frame(10, 6, 0, 0, "R3 R4 R5 random L1");
  endtask

  task automatic t_random_linf();
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) img[r][c] = rnd();
    run_frame(10, 6, 1, 0, "R6 random Linf");
  endtask

  task automatic t_saturate();
    bit seen_cap = 0;
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) img[r][c] = (r + c >= 6) ? 255 : 0;
    run_frame(8, 6, 0, 0, "R7 diagonal L1");
    foreach (out_val[k]) if (out_val[k] == CAPV) seen_cap = 1;
    check(seen_cap, "R7 clipped value seen", int'(seen_cap), 1);
    run_frame(8, 6, 1, 0, "R6 diagonal Linf");
  endtask

  task automatic t_gaps_alt();
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) img[r][c] = rnd();
    run_frame(8, 5, 2, 2, "R9 R10 gaps alternate norm");
  endtask

  task automatic t_line_lengths();
    for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) img[r][c] = rnd();
    run_frame(3, 5, 0, 0, "R11 short line");
    run_frame(LW, 4, 2, 0, "R11 full line");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_eol = 1'b0; norm_sel = 1'b0; in_pix = '0;
    @(negedge clk);
    t_ramp_l1();
    t_random_l1();
    t_random_linf();
    t_saturate();
    t_gaps_alt();
    t_line_lengths();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule